// File: doc/BRIEF.md
# Serial Link Initialization Sequencer

This block is the state machine that brings a buffered memory-module serial link from power-up to the active state. Each southbound bit lane delivers a decoded 3-bit status every frame period. The sequencer filters each lane for stability and counts the participating lanes that agree on a pattern. It takes a transition only when at least a programmable minimum number of lanes agree.

The bring-up order is fixed: disable, calibrate, back to disable, training, testing, polling, config, and then the active state. The active state has two side states. Recalibrate idles the channel with NOPs. The optional low-power idle is enabled by a configuration input. Lanes that do not show the pattern that triggered a transition are dropped from a participating mask, so a faulty lane cannot block the others.

The outputs are the current state, the northbound transmit pattern for that state, the participating-lane mask, a one-cycle pulse on each state change, and a link-up flag.

Top module: `link_init_seq`

## Requirements
- R1: After reset the state is disable (code 0). The transmit pattern is electrical idle (code 0), every lane is participating, `link_up` is 0 and `state_chg` is 0.
- R2: Lane pattern codes are as follows. Lane i uses bits [3i+2:3i] of `lane_code`. The values are 0 electrical idle, 1 calibrate, 2 TS0, 3 TS1, 4 TS2, 5 TS3, 6 NOP and 7 frame. A lane counts toward a vote only after it has shown the same code on `stable_frames` consecutive sampled frame periods. The state changes on the clock edge after the lane becomes qualified.
- R3: A transition is taken only when the number of qualified, participating lanes that show its trigger code is at least `min_lanes`. A threshold of 0 acts as 1.
- R4: State codes are 0 disable, 1 calibrate, 2 training, 3 testing, 4 polling, 5 config, 6 active, 7 recalibrate and 8 low-power idle. Disable moves to calibrate on a calibrate vote. Calibrate returns to disable on an idle vote and marks the link calibrated. Disable moves to training on a TS0 vote only when the link is calibrated. Training moves to testing on TS1, testing moves to polling on TS2, polling moves to config on TS3, and config moves to active on frame.
- R5: The transmit pattern is the code each state drives. Disable and low-power idle drive 0. Calibrate drives 1, training 2, testing 3, polling 4 and config 5. Active drives 7 and recalibrate drives 6.
- R6: On each forward transition, lanes that did not vote for the trigger code leave the participating mask. Lanes outside the mask are ignored by every later vote. Every entry into disable restores the full mask.
- R7: The active state moves to recalibrate on a NOP vote. Recalibrate returns to active on a frame vote.
- R8: With `l0s_en` high, an idle vote in the active state enters low-power idle. An idle vote never aborts low-power idle, and a frame vote returns it to active. With `l0s_en` low, an idle vote in the active state goes to disable.
- R9: In any state other than disable and low-power idle, an idle vote forces disable. This abort clears the calibrated mark, except when it is the normal exit from calibrate.
- R10: If training, testing, polling or config sees no exit vote for `timeout_frames` sampled frame periods, the machine returns to disable and clears the calibrated mark. It stays in the state for exactly `timeout_frames`+1 cycles when a frame period is sampled every cycle.
- R11: `state_chg` pulses high for one cycle in the cycle the new state first appears. `link_up` is high exactly while the state is active.
- R12: While `frame_tick` is low, the lane filters do not advance, so lane changes cannot trigger transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame period; lanes are sampled on it |
| lane_code | input | 3*NUM_LANES | Decoded southbound status per lane |
| min_lanes | input | CNT_W | Minimum agreeing lanes for a transition |
| stable_frames | input | STB_W | Consecutive equal samples before a lane qualifies |
| timeout_frames | input | TO_W | Frame periods allowed in each timed state |
| l0s_en | input | 1 | Enables the low-power idle side state |
| link_state | output | 4 | Current state code |
| tx_pattern | output | 3 | Northbound transmit pattern code |
| part_mask | output | NUM_LANES | Participating-lane mask |
| state_chg | output | 1 | One-cycle pulse on every state change |
| link_up | output | 1 | High while in the active state |

## Verification
The bench first sends TS0 before calibration. A design that skips the calibrate round trip would start training too early. It then holds a new code for exactly one frame too few, which catches a filter that qualifies a lane early. Two lanes are left stuck at idle so they drop out of the mask. Those lanes are later shown the trigger code while one lane short of the threshold is agreeing. A design that counts dropped lanes would advance in that case. The bench also checks the following:
- Low-power idle rides out a full idle vote without aborting.
- The timeout window is exact to the cycle.
- A stalled `frame_tick` freezes the lane filters.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

  typedef enum logic [2:0] {
    PAT_IDLE  = 3'd0,
    PAT_CAL   = 3'd1,
    PAT_TS0   = 3'd2,
    PAT_TS1   = 3'd3,
    PAT_TS2   = 3'd4,
    PAT_TS3   = 3'd5,
    PAT_NOP   = 3'd6,
    PAT_FRAME = 3'd7
  } lane_pat_t;

  typedef enum logic [3:0] {
    ST_DISABLE = 4'd0,
    ST_CALIB   = 4'd1,
    ST_TRAIN   = 4'd2,
    ST_TEST    = 4'd3,
    ST_POLL    = 4'd4,
    ST_CONFIG  = 4'd5,
    ST_ACTIVE  = 4'd6,
    ST_RECAL   = 4'd7,
    ST_LOWPWR  = 4'd8
  } link_state_t;

  function automatic lane_pat_t tx_of(input link_state_t s);
    case (s)
      ST_CALIB:  return PAT_CAL;
      ST_TRAIN:  return PAT_TS0;
      ST_TEST:   return PAT_TS1;
      ST_POLL:   return PAT_TS2;
      ST_CONFIG: return PAT_TS3;
      ST_ACTIVE: return PAT_FRAME;
      ST_RECAL:  return PAT_NOP;
      default:   return PAT_IDLE;
    endcase
  endfunction

  function automatic logic is_timed(input link_state_t s);
    return (s == ST_TRAIN) || (s == ST_TEST) || (s == ST_POLL) || (s == ST_CONFIG);
  endfunction

endpackage

// File: rtl/lane_filter.sv
module lane_filter #(
  parameter int STB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       code,
  input  logic [STB_W-1:0] stable_frames,
  output logic [2:0]       held_code,
  output logic             qualified
);
  localparam logic [STB_W-1:0] CNT_MAX = '1;

  logic [STB_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_code <= 3'd0;
      run_q     <= '0;
    end else if (tick) begin
      if (code != held_code) begin
        held_code <= code;
        run_q     <= STB_W'(1);
      end else if (run_q != CNT_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign qualified = (run_q >= stable_frames);
endmodule

// File: rtl/lane_vote.sv
module lane_vote #(
  parameter int NUM_LANES = 10,
  parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic [NUM_LANES*3-1:0]       codes,
  input  logic [NUM_LANES-1:0]         qual,
  input  logic [NUM_LANES-1:0]         part,
  input  logic [CNT_W-1:0]             min_lanes,
  output logic [7:0]                   vote_ok,
  output logic [7:0][NUM_LANES-1:0]    vote_mask
);
  function automatic logic [CNT_W-1:0] ones(input logic [NUM_LANES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_LANES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic meets(input logic [CNT_W-1:0] n, input logic [CNT_W-1:0] thr);
    return (thr == '0) ? (n != '0) : (n >= thr);
  endfunction

  for (genvar p = 0; p < 8; p++) begin : g_pat
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign vote_mask[p][l] = part[l] & qual[l] & (codes[3*l +: 3] == 3'(p));
    end
    assign vote_ok[p] = meets(ones(vote_mask[p]), min_lanes);
  end
endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import link_init_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int TO_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [7:0]                    vote_ok,
  input  logic [7:0][NUM_LANES-1:0]     vote_mask,
  input  logic                          l0s_en,
  input  logic [TO_W-1:0]               timeout_frames,
  output link_state_t                   state_q,
  output logic [NUM_LANES-1:0]          part_q,
  output logic                          chg_q,
  output logic                          timeout_hit,
  output logic                          abort_hit
);
  localparam logic [TO_W-1:0] TO_MAX = '1;

  link_state_t state_d, fwd_d;
  lane_pat_t   trig;
  logic        fwd;
  logic        cal_done_q;
  logic [TO_W-1:0] to_cnt_q;

  always_comb begin
    fwd   = 1'b0;
    fwd_d = state_q;
    trig  = PAT_IDLE;
    case (state_q)
      ST_DISABLE: if (vote_ok[PAT_CAL]) begin
                    fwd = 1'b1; fwd_d = ST_CALIB; trig = PAT_CAL;
                  end else if (cal_done_q && vote_ok[PAT_TS0]) begin
                    fwd = 1'b1; fwd_d = ST_TRAIN; trig = PAT_TS0;
                  end
      ST_TRAIN:   if (vote_ok[PAT_TS1])   begin fwd = 1'b1; fwd_d = ST_TEST;   trig = PAT_TS1;   end
      ST_TEST:    if (vote_ok[PAT_TS2])   begin fwd = 1'b1; fwd_d = ST_POLL;   trig = PAT_TS2;   end
      ST_POLL:    if (vote_ok[PAT_TS3])   begin fwd = 1'b1; fwd_d = ST_CONFIG; trig = PAT_TS3;   end
      ST_CONFIG:  if (vote_ok[PAT_FRAME]) begin fwd = 1'b1; fwd_d = ST_ACTIVE; trig = PAT_FRAME; end
      ST_ACTIVE:  if (vote_ok[PAT_NOP]) begin
                    fwd = 1'b1; fwd_d = ST_RECAL; trig = PAT_NOP;
                  end else if (vote_ok[PAT_IDLE] && l0s_en) begin
                    fwd = 1'b1; fwd_d = ST_LOWPWR; trig = PAT_IDLE;
                  end
      ST_RECAL:   if (vote_ok[PAT_FRAME]) begin fwd = 1'b1; fwd_d = ST_ACTIVE; trig = PAT_FRAME; end
      ST_LOWPWR:  if (vote_ok[PAT_FRAME]) begin fwd = 1'b1; fwd_d = ST_ACTIVE; trig = PAT_FRAME; end
      default: ;
    endcase

    abort_hit   = vote_ok[PAT_IDLE] && (state_q != ST_DISABLE) && (state_q != ST_LOWPWR)
                  && !(state_q == ST_ACTIVE && l0s_en);
    timeout_hit = !abort_hit && !fwd && is_timed(state_q) && (to_cnt_q >= timeout_frames);

    if (abort_hit || timeout_hit) state_d = ST_DISABLE;
    else                          state_d = fwd_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_DISABLE;
      part_q     <= '1;
      chg_q      <= 1'b0;
      cal_done_q <= 1'b0;
      to_cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      chg_q   <= (state_d != state_q);
      if (state_d != state_q) to_cnt_q <= '0;
      else if (tick && is_timed(state_q) && to_cnt_q != TO_MAX) to_cnt_q <= to_cnt_q + 1'b1;
      if (abort_hit || timeout_hit) begin
        part_q     <= '1;
        cal_done_q <= abort_hit && (state_q == ST_CALIB);
      end else if (fwd) begin
        part_q <= part_q & vote_mask[trig];
      end
    end
  end
endmodule

// File: rtl/link_init_seq.sv
module link_init_seq
  import link_init_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int STB_W     = 4,
  parameter int TO_W      = 16,
  parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic [NUM_LANES*3-1:0] lane_code,
  input  logic [CNT_W-1:0]       min_lanes,
  input  logic [STB_W-1:0]       stable_frames,
  input  logic [TO_W-1:0]        timeout_frames,
  input  logic                   l0s_en,
  output logic [3:0]             link_state,
  output logic [2:0]             tx_pattern,
  output logic [NUM_LANES-1:0]   part_mask,
  output logic                   state_chg,
  output logic                   link_up
);
  logic [NUM_LANES*3-1:0]      held;
  logic [NUM_LANES-1:0]        qual;
  logic [7:0]                  vote_ok;
  logic [7:0][NUM_LANES-1:0]   vote_mask;
  link_state_t                 state_e;
  logic                        timeout_hit;
  logic                        abort_hit;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lane_filter #(.STB_W(STB_W)) filt_i (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick),
      .code(lane_code[3*l +: 3]), .stable_frames(stable_frames),
      .held_code(held[3*l +: 3]), .qualified(qual[l])
    );
  end

  lane_vote #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) vote_i (
    .codes(held), .qual(qual), .part(part_mask), .min_lanes(min_lanes),
    .vote_ok(vote_ok), .vote_mask(vote_mask)
  );

  link_fsm #(.NUM_LANES(NUM_LANES), .TO_W(TO_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick),
    .vote_ok(vote_ok), .vote_mask(vote_mask), .l0s_en(l0s_en),
    .timeout_frames(timeout_frames),
    .state_q(state_e), .part_q(part_mask), .chg_q(state_chg),
    .timeout_hit(timeout_hit), .abort_hit(abort_hit)
  );

  assign link_state = state_e;
  assign tx_pattern = tx_of(state_e);
  assign link_up    = (state_e == ST_ACTIVE);
endmodule

// File: rtl/link_init_seq_chk.sv
module link_init_seq_chk #(
  parameter int NUM_LANES = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           link_state,
  input logic [2:0]           tx_pattern,
  input logic [NUM_LANES-1:0] part_mask,
  input logic                 state_chg,
  input logic                 link_up,
  input logic                 timeout_hit,
  input logic                 abort_hit
);
  assert_chg_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> (link_state != $past(link_state)));

  assert_linkup_frames_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (tx_pattern == 3'd7));

  assert_disable_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 4'd0) |-> (tx_pattern == 3'd0));

  assert_lowpwr_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 4'd8) |=> (link_state == 4'd8 || link_state == 4'd6));

  assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (link_state == 4'd0));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (link_state == 4'd0 && part_mask == '1));

  assert_mask_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state != 4'd0) |=> (link_state == 4'd0 || (part_mask & ~$past(part_mask)) == '0));

  assert_recal_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 4'd7 && $past(link_state) != 4'd7) |-> ($past(link_state) == 4'd6));
endmodule

bind link_init_seq link_init_seq_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .link_state(link_state), .tx_pattern(tx_pattern),
  .part_mask(part_mask), .state_chg(state_chg), .link_up(link_up),
  .timeout_hit(timeout_hit), .abort_hit(abort_hit)
);

// File: tb/link_init_seq_tb_top.sv
module link_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL    = 8;
  localparam int STB_W = 4;
  localparam int TO_W  = 16;
  localparam int CNT_W = $clog2(NL + 1);
  localparam int TMO   = 20;

  localparam logic [3:0] S_DIS = 0, S_CAL = 1, S_TRN = 2, S_TST = 3, S_POL = 4,
                         S_CFG = 5, S_ACT = 6, S_RCL = 7, S_LPW = 8;
  localparam logic [2:0] C_IDLE = 0, C_CAL = 1, C_TS0 = 2, C_TS1 = 3, C_TS2 = 4,
                         C_TS3 = 5, C_NOP = 6, C_FRM = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b1;
  logic [NL*3-1:0] lane_code = '0;
  logic [CNT_W-1:0] min_lanes = CNT_W'(6);
  logic [STB_W-1:0] stable_frames = STB_W'(2);
  logic [TO_W-1:0] timeout_frames = TO_W'(TMO);
  logic l0s_en = 1'b0;
  logic [3:0] link_state;
  logic [2:0] tx_pattern;
  logic [NL-1:0] part_mask;
  logic state_chg, link_up;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  link_init_seq #(.NUM_LANES(NL), .STB_W(STB_W), .TO_W(TO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .lane_code(lane_code),
    .min_lanes(min_lanes), .stable_frames(stable_frames), .timeout_frames(timeout_frames),
    .l0s_en(l0s_en), .link_state(link_state), .tx_pattern(tx_pattern),
    .part_mask(part_mask), .state_chg(state_chg), .link_up(link_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [2:0] c);
    for (int i = 0; i < NL; i++) lane_code[3*i +: 3] = c;
  endtask

  task automatic set_lane(input int i, input logic [2:0] c);
    lane_code[3*i +: 3] = c;
  endtask

  task automatic wait_st(input logic [3:0] s, input int maxc, input string req);
    int n = 0;
    while (link_state != s && n < maxc) begin @(negedge clk); n++; end
    chk(link_state == s, req, link_state, s);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every state change pulse pops the next expected state
  always @(negedge clk) begin
    if (rst_n && state_chg && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected state change", link_state, -1);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(link_state == e, "R11 scoreboard state", link_state, e);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(1);
    // R1 reset state
    chk(link_state == S_DIS, "R1 state", link_state, S_DIS);
    chk(tx_pattern == C_IDLE, "R1 tx", tx_pattern, C_IDLE);
    chk(part_mask == '1, "R1 mask", part_mask, 8'hFF);
    chk(link_up == 0 && state_chg == 0, "R1 flags", {link_up, state_chg}, 0);

    // R4: TS0 before calibration is ignored
    set_all(C_TS0); hold(8);
    chk(link_state == S_DIS, "R4 no training before calibrate", link_state, S_DIS);

    // R2: filter latency, exact
    exp_q.push_back(S_CAL);
    set_all(C_CAL);
    hold(2);
    chk(link_state == S_DIS, "R2 lane not yet qualified", link_state, S_DIS);
    hold(1);
    chk(link_state == S_CAL, "R2 transition after qualify", link_state, S_CAL);
    chk(tx_pattern == C_CAL && state_chg, "R5 calibrate tx and R11 pulse", tx_pattern, C_CAL);
    hold(1);
    chk(!state_chg, "R11 pulse one cycle", state_chg, 0);

    // R4 back to disable, then R6 training with lanes 6,7 stuck idle
    exp_q.push_back(S_DIS);
    set_all(C_IDLE); wait_st(S_DIS, 6, "R4 calibrate back to disable");
    exp_q.push_back(S_TRN);
    set_all(C_TS0); set_lane(6, C_IDLE); set_lane(7, C_IDLE);
    wait_st(S_TRN, 6, "R4 training after calibration");
    chk(part_mask == 8'h3F, "R6 stuck lanes dropped", part_mask, 8'h3F);
    chk(tx_pattern == C_TS0, "R5 training tx", tx_pattern, C_TS0);

    // R3: 5 participating lanes + 2 dropped lanes show TS1 -> no move
    for (int i = 0; i < 5; i++) set_lane(i, C_TS1);
    set_lane(6, C_TS1); set_lane(7, C_TS1);
    hold(6);
    chk(link_state == S_TRN, "R3 below threshold, dropped lanes ignored", link_state, S_TRN);
    exp_q.push_back(S_TST);
    set_lane(5, C_TS1);
    wait_st(S_TST, 6, "R3 threshold reached");
    chk(part_mask == 8'h3F, "R6 mask kept", part_mask, 8'h3F);

    exp_q.push_back(S_POL); set_all(C_TS2); wait_st(S_POL, 6, "R4 polling");
    chk(tx_pattern == C_TS2, "R5 polling tx", tx_pattern, C_TS2);
    exp_q.push_back(S_CFG); set_all(C_TS3); wait_st(S_CFG, 6, "R4 config");
    exp_q.push_back(S_ACT); set_all(C_FRM); wait_st(S_ACT, 6, "R4 active");
    chk(link_up && tx_pattern == C_FRM, "R11 link_up in active, R5 tx", tx_pattern, C_FRM);

    // R7 recalibrate
    exp_q.push_back(S_RCL); set_all(C_NOP); wait_st(S_RCL, 6, "R7 recalibrate");
    chk(tx_pattern == C_NOP && !link_up, "R7 recal tx NOP", tx_pattern, C_NOP);
    exp_q.push_back(S_ACT); set_all(C_FRM); wait_st(S_ACT, 6, "R7 back to active");

    // R8 low-power idle
    l0s_en = 1'b1;
    exp_q.push_back(S_LPW); set_all(C_IDLE); wait_st(S_LPW, 6, "R8 enter low-power");
    hold(8);
    chk(link_state == S_LPW, "R8 idle does not abort low-power", link_state, S_LPW);
    chk(tx_pattern == C_IDLE && !link_up, "R8 low-power tx idle", tx_pattern, C_IDLE);
    exp_q.push_back(S_ACT); set_all(C_FRM); wait_st(S_ACT, 6, "R8 exit low-power");

    // R8/R9: disabled low-power -> idle aborts to disable
    l0s_en = 1'b0;
    exp_q.push_back(S_DIS); set_all(C_IDLE); wait_st(S_DIS, 6, "R9 idle abort");
    chk(part_mask == '1, "R6 mask restored in disable", part_mask, 8'hFF);

    // R10 timeout in training
    exp_q.push_back(S_CAL); set_all(C_CAL); wait_st(S_CAL, 6, "R4 recalibrate link");
    exp_q.push_back(S_DIS); set_all(C_IDLE); wait_st(S_DIS, 6, "R4 back to disable");
    exp_q.push_back(S_TRN); set_all(C_TS0); wait_st(S_TRN, 6, "R4 training again");
    exp_q.push_back(S_DIS);
    begin
      int n = 1;
      @(negedge clk);
      while (link_state == S_TRN && n < 100) begin n++; @(negedge clk); end
      chk(n == TMO + 1, "R10 timeout window", n, TMO + 1);
      chk(link_state == S_DIS, "R10 back to disable", link_state, S_DIS);
    end
    hold(6);
    chk(link_state == S_DIS, "R10 calibrated mark cleared", link_state, S_DIS);

    // R12 tick gating
    frame_tick = 1'b0;
    set_all(C_CAL); hold(8);
    chk(link_state == S_DIS, "R12 no advance without tick", link_state, S_DIS);
    exp_q.push_back(S_CAL);
    frame_tick = 1'b1;
    wait_st(S_CAL, 6, "R12 advance after tick resumes");

    hold(2);
    chk(exp_q.size() == 0, "R11 all expected changes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule